// File: doc/BRIEF.md
# Refresh Row Counter with Skip and Register Access

This block models the refresh row counter that lives inside one DRAM device. It holds the index of the next refresh group, which is the set of rows refreshed together by one refresh operation. It drives that index to the array along with a one-cycle strobe for each real refresh. The counter advances whenever the device refreshes a group. This happens on an auto-refresh command from the controller, once on entry into self-refresh, and on every tick of the internal oscillator while the device stays in self-refresh.

A controller that knows some groups need no refresh can send a dummy-refresh command. This command steps the counter past the current group without touching the array. The counter can also be read through the control-register path and overwritten by a register-write command. A controller can therefore learn where each device stands and bring several devices back into step.

Read-back data leaves the block on a valid-only stream. `rd_valid` is high for exactly one cycle per read command, and `rd_data` carries the counter value. There is no ready input and the stream cannot be held back: the consumer must take the word in the cycle it appears. Reads issued back to back produce valid words in consecutive cycles.

Top module: `refcnt_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `row_addr` is 0 and `ref_strobe`, `ref_row`, `proto_err`, `rd_valid` and `rd_data` are all 0. The device starts outside self-refresh.
- R2: Outside self-refresh, an auto-refresh command in cycle t does three things. It raises `ref_strobe` in cycle t+1. It sets `ref_row` in cycle t+1 to the `row_addr` of cycle t. It advances `row_addr` by one in cycle t+1. `ref_row` holds its value between strobes.
- R3: The counter counts modulo NUM_GROUPS, so advancing from NUM_GROUPS-1 gives 0, and `row_addr` never reaches NUM_GROUPS or more.
- R4: Outside self-refresh, a dummy-refresh command advances `row_addr` by one in the next cycle and raises no `ref_strobe`. When auto-refresh and dummy-refresh arrive in the same cycle, the counter advances only once.
- R5: Self-refresh entry outside self-refresh performs one refresh at once: strobe and advance as in R2. The device is in self-refresh from the next cycle. An auto-refresh in the same cycle as entry adds no second refresh.
- R6: In self-refresh, each `osc_tick` performs one refresh, with strobe and advance as in R2. Outside self-refresh, `osc_tick` has no effect.
- R7: In self-refresh, auto-refresh and dummy-refresh commands perform no refresh and do not move the counter. Each one raises `proto_err` for the following cycle.
- R8: A counter read in cycle t raises `rd_valid` in cycle t+RD_LAT, with `rd_data` equal to the `row_addr` of cycle t. When `rd_valid` is low, `rd_data` is 0.
- R9: A counter write in cycle t sets `row_addr` in cycle t+1 to `wr_value`, or to 0 if `wr_value` is NUM_GROUPS or more. It overrides any advance in the same cycle. A refresh in that same cycle still strobes the old row.
- R10: Self-refresh exit in self-refresh returns the device to normal operation from the next cycle. A tick in the exit cycle still refreshes. Exit outside self-refresh and entry inside self-refresh are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_auto_ref | input | 1 | Decoded auto-refresh command |
| cmd_dummy_ref | input | 1 | Decoded dummy-refresh (skip) command |
| cmd_sr_enter | input | 1 | Decoded self-refresh entry |
| cmd_sr_exit | input | 1 | Decoded self-refresh exit |
| cmd_cnt_rd | input | 1 | Counter read through the register path |
| cmd_cnt_wr | input | 1 | Counter write through the register path |
| wr_value | input | ROW_W | Value for a counter write |
| osc_tick | input | 1 | Self-refresh oscillator tick |
| row_addr | output | ROW_W | Current counter (next group to refresh) |
| ref_strobe | output | 1 | One-cycle pulse per real refresh |
| ref_row | output | ROW_W | Group refreshed by the latest strobe |
| proto_err | output | 1 | Pulse for a refresh command received in self-refresh |
| rd_valid | output | 1 | Read-back word valid |
| rd_data | output | ROW_W | Read-back counter value |

## Verification
On every cycle, the assertions check several properties. The counter must stay in range. A strobe must be matched by a one-step advance from the refreshed row, unless a write landed. Dummy commands outside self-refresh must produce no strobe. Entry must refresh once. Refresh commands inside self-refresh must leave the counter still and raise the error pulse. A write must land as given.

Other behaviours are shown only by the bench's scenarios, where a cycle-accurate reference model is compared on each clock. These include the read latency and the zeroing of idle read data, the wrap of a non-power-of-two group count, the clamping of out-of-range writes, ticks that are ignored outside self-refresh, and the exit and entry corner cases.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;

  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SELF   = 1'b1
  } sr_mode_e;

  // Counter width for a given number of refresh groups (at least one bit).
  function automatic int unsigned groups_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/refcnt_sr_ctrl.sv
module refcnt_sr_ctrl
  import refcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_auto_ref,
  input  logic cmd_dummy_ref,
  input  logic cmd_sr_enter,
  input  logic cmd_sr_exit,
  input  logic osc_tick,
  output logic sr_active,
  output logic ref_evt,
  output logic adv_evt,
  output logic proto_err
);

  sr_mode_e mode_q, mode_d;
  logic     err_d;

  // Decide, per cycle, whether a real refresh and/or a counter step happens.
  always_comb begin
    mode_d  = mode_q;
    ref_evt = 1'b0;
    adv_evt = 1'b0;
    err_d   = 1'b0;
    unique case (mode_q)
      MODE_ACTIVE: begin
        ref_evt = cmd_auto_ref | cmd_sr_enter;
        adv_evt = cmd_auto_ref | cmd_sr_enter | cmd_dummy_ref;
        if (cmd_sr_enter) mode_d = MODE_SELF;
      end
      MODE_SELF: begin
        ref_evt = osc_tick;
        adv_evt = osc_tick;
        err_d   = cmd_auto_ref | cmd_dummy_ref;
        if (cmd_sr_exit) mode_d = MODE_ACTIVE;
      end
      default: begin
        mode_d = MODE_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_ACTIVE;
      proto_err <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      proto_err <= err_d;
    end
  end

  assign sr_active = (mode_q == MODE_SELF);

endmodule

// File: rtl/refcnt_counter.sv
module refcnt_counter #(
  parameter int unsigned NUM_GROUPS = 8192,
  parameter int unsigned ROW_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_value,
  output logic [ROW_W-1:0] cnt
);

  localparam int unsigned LAST = NUM_GROUPS - 1;
  localparam bit          POW2 = ((64'd1 << ROW_W) == 64'(NUM_GROUPS));

  logic [ROW_W-1:0] cnt_q;
  logic [ROW_W-1:0] inc_val;
  logic [ROW_W-1:0] load_val;

  generate
    if (POW2) begin : g_pow2
      // Natural binary rollover is already the modulo wrap.
      assign inc_val  = cnt_q + ROW_W'(1);
      assign load_val = wr_value;
    end else begin : g_mod
      assign inc_val  = (cnt_q == ROW_W'(LAST)) ? '0 : cnt_q + ROW_W'(1);
      assign load_val = (32'(wr_value) < NUM_GROUPS) ? wr_value : '0;
    end
  endgenerate

  // A register write beats any step in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= load_val;
    end else if (adv) begin
      cnt_q <= inc_val;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/refcnt_rd_pipe.sv
module refcnt_rd_pipe #(
  parameter int unsigned W   = 13,
  parameter int unsigned LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         vld_q [LAT];
  logic [W-1:0] dat_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end
    end else begin
      vld_q[0] <= in_valid;
      dat_q[0] <= in_valid ? in_data : '0;
      for (int s = 1; s < LAT; s++) begin
        vld_q[s] <= vld_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_data  = dat_q[LAT-1];

endmodule

// File: rtl/refcnt_top.sv
module refcnt_top #(
  parameter  int unsigned NUM_GROUPS = 8192,
  parameter  int unsigned RD_LAT     = 2,
  localparam int unsigned ROW_W      = refcnt_pkg::groups_width(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_auto_ref,
  input  logic             cmd_dummy_ref,
  input  logic             cmd_sr_enter,
  input  logic             cmd_sr_exit,
  input  logic             cmd_cnt_rd,
  input  logic             cmd_cnt_wr,
  input  logic [ROW_W-1:0] wr_value,
  input  logic             osc_tick,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_strobe,
  output logic [ROW_W-1:0] ref_row,
  output logic             proto_err,
  output logic             rd_valid,
  output logic [ROW_W-1:0] rd_data
);

  logic             sr_active;
  logic             ref_evt;
  logic             adv_evt;
  logic [ROW_W-1:0] cnt;
  logic             strobe_q;
  logic [ROW_W-1:0] row_q;

  refcnt_sr_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_auto_ref (cmd_auto_ref),
    .cmd_dummy_ref(cmd_dummy_ref),
    .cmd_sr_enter (cmd_sr_enter),
    .cmd_sr_exit  (cmd_sr_exit),
    .osc_tick     (osc_tick),
    .sr_active    (sr_active),
    .ref_evt      (ref_evt),
    .adv_evt      (adv_evt),
    .proto_err    (proto_err)
  );

  refcnt_counter #(
    .NUM_GROUPS(NUM_GROUPS),
    .ROW_W     (ROW_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_evt),
    .wr_en   (cmd_cnt_wr),
    .wr_value(wr_value),
    .cnt     (cnt)
  );

  refcnt_rd_pipe #(
    .W  (ROW_W),
    .LAT(RD_LAT)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_cnt_rd),
    .in_data  (cnt),
    .out_valid(rd_valid),
    .out_data (rd_data)
  );

  // Array-side strobe with the group that was refreshed.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      row_q    <= '0;
    end else begin
      strobe_q <= ref_evt;
      if (ref_evt) row_q <= cnt;
    end
  end

  assign row_addr   = cnt;
  assign ref_strobe = strobe_q;
  assign ref_row    = row_q;

endmodule

// File: rtl/refcnt_chk.sv
module refcnt_chk #(
  parameter int unsigned NUM_GROUPS = 8192,
  parameter int unsigned ROW_W      = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_auto_ref,
  input logic             cmd_dummy_ref,
  input logic             cmd_sr_enter,
  input logic             cmd_cnt_wr,
  input logic [ROW_W-1:0] wr_value,
  input logic             osc_tick,
  input logic [ROW_W-1:0] row_addr,
  input logic             ref_strobe,
  input logic [ROW_W-1:0] ref_row,
  input logic             proto_err,
  input logic             sr_active
);

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_addr) < NUM_GROUPS);

  assert_strobe_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe && !$past(cmd_cnt_wr)) |->
      row_addr == ((ref_row == ROW_W'(NUM_GROUPS - 1)) ? '0 : ref_row + ROW_W'(1)));

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dummy_ref && !sr_active && !cmd_auto_ref && !cmd_sr_enter) |=> !ref_strobe);

  assert_entry_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_enter && !sr_active) |=> (ref_strobe && sr_active));

  assert_sr_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_active && (cmd_auto_ref || cmd_dummy_ref) && !osc_tick && !cmd_cnt_wr) |=>
      (!ref_strobe && proto_err && row_addr == $past(row_addr)));

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cnt_wr && 32'(wr_value) < NUM_GROUPS) |=> row_addr == $past(wr_value));

endmodule

bind refcnt_top refcnt_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .ROW_W     (ROW_W)
) u_chk (.*);

// File: tb/refcnt_top_tb.sv
`timescale 1ns/1ps
module refcnt_top_tb;

  localparam int unsigned NG  = 12;
  localparam int unsigned LAT = 3;
  localparam int unsigned W   = $clog2(NG);

  localparam int C_AR = 1, C_DR = 2, C_EN = 4, C_EX = 8, C_RD = 16, C_WR = 32, C_TK = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_auto_ref, cmd_dummy_ref, cmd_sr_enter, cmd_sr_exit;
  logic         cmd_cnt_rd, cmd_cnt_wr, osc_tick;
  logic [W-1:0] wr_value;
  logic [W-1:0] row_addr, ref_row, rd_data;
  logic         ref_strobe, proto_err, rd_valid;

  always #2 clk = ~clk;

  refcnt_top #(.NUM_GROUPS(NG), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_auto_ref(cmd_auto_ref), .cmd_dummy_ref(cmd_dummy_ref),
    .cmd_sr_enter(cmd_sr_enter), .cmd_sr_exit(cmd_sr_exit),
    .cmd_cnt_rd(cmd_cnt_rd), .cmd_cnt_wr(cmd_cnt_wr), .wr_value(wr_value),
    .osc_tick(osc_tick), .row_addr(row_addr), .ref_strobe(ref_strobe),
    .ref_row(ref_row), .proto_err(proto_err), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Reference model state
  int m_cnt = 0, m_sr = 0, m_strobe = 0, m_row = 0, m_err = 0;
  int e_rv = 0, e_rd = 0;
  int rq_v[$];
  int rq_d[$];

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("row_addr",   int'(row_addr),   m_cnt);
    check("ref_strobe", int'(ref_strobe), m_strobe);
    check("ref_row",    int'(ref_row),    m_row);
    check("proto_err",  int'(proto_err),  m_err);
    check("rd_valid",   int'(rd_valid),   e_rv);
    check("rd_data",    int'(rd_data),    e_rd);
  endtask

  task automatic op(input int cmds, input int wv = 0);
    bit a, d, en, ex, rd, wr, tk, ev, adv;
    a  = (cmds & C_AR) != 0; d  = (cmds & C_DR) != 0;
    en = (cmds & C_EN) != 0; ex = (cmds & C_EX) != 0;
    rd = (cmds & C_RD) != 0; wr = (cmds & C_WR) != 0;
    tk = (cmds & C_TK) != 0;
    cmd_auto_ref = a; cmd_dummy_ref = d; cmd_sr_enter = en; cmd_sr_exit = ex;
    cmd_cnt_rd = rd; cmd_cnt_wr = wr; osc_tick = tk; wr_value = W'(wv);
    // model next state from current state and inputs
    ev  = (m_sr == 0) ? (a || en) : tk;
    adv = ev || ((m_sr == 0) && d);
    rq_v.push_back(rd ? 1 : 0);
    rq_d.push_back(rd ? m_cnt : 0);
    e_rv = rq_v.pop_front();
    e_rd = rq_d.pop_front();
    m_err    = (m_sr != 0 && (a || d)) ? 1 : 0;
    m_strobe = ev ? 1 : 0;
    if (ev) m_row = m_cnt;
    if (wr) m_cnt = (wv < NG) ? wv : 0;
    else if (adv) m_cnt = (m_cnt + 1) % NG;
    if (m_sr == 0 && en) m_sr = 1;
    else if (m_sr != 0 && ex) m_sr = 0;
    @(posedge clk);
    @(negedge clk);
    cmd_auto_ref = 0; cmd_dummy_ref = 0; cmd_sr_enter = 0; cmd_sr_exit = 0;
    cmd_cnt_rd = 0; cmd_cnt_wr = 0; osc_tick = 0;
    compare_all();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cmd_auto_ref = 0; cmd_dummy_ref = 0; cmd_sr_enter = 0; cmd_sr_exit = 0;
    cmd_cnt_rd = 0; cmd_cnt_wr = 0; osc_tick = 0; wr_value = '0;
    for (int i = 0; i < int'(LAT) - 1; i++) begin
      rq_v.push_back(0);
      rq_d.push_back(0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1"; compare_all();        // during reset
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    compare_all();                    // first cycle after reset

    tag = "R2";                       // auto-refresh steps and strobes
    op(C_AR); op(0); op(C_AR); op(C_AR); op(0);

    tag = "R4";                       // skip without strobe, and combined with auto
    op(C_DR); op(C_DR); op(0); op(C_DR | C_AR); op(0);

    tag = "R6";                       // tick outside self-refresh ignored
    op(C_TK); op(0);

    tag = "R8";                       // read latency and back-to-back reads
    op(C_RD); op(C_RD | C_AR); op(0); op(0); op(0); op(0);
    op(C_RD | C_DR); op(0); op(C_RD); op(0); op(0); op(0); op(0);

    tag = "R9";                       // writes, clamp, priority over steps
    op(C_WR, 9); op(C_WR | C_AR, 2); op(0); op(C_WR, 15); op(C_WR | C_DR, 7); op(0);

    tag = "R3";                       // wrap at NUM_GROUPS
    op(C_WR, 10); op(C_AR); op(C_AR); op(0);
    op(C_WR, 11); op(C_DR); op(0);
    for (int i = 0; i < 30; i++) op(C_DR);
    op(0);

    tag = "R5";                       // entry with coincident auto-refresh
    op(C_EN | C_AR); op(0);

    tag = "R6";                       // ticks in self-refresh
    op(C_TK); op(0); op(C_TK); op(C_TK); op(0);

    tag = "R7";                       // refresh commands inside self-refresh
    op(C_AR); op(C_DR); op(0); op(C_AR | C_TK); op(0);

    tag = "R10";                      // entry inside, exit corner cases
    op(C_EN); op(0); op(C_EX | C_TK); op(C_TK); op(C_EX); op(C_AR); op(C_DR); op(0);

    tag = "R5";                       // plain entry then exit
    op(C_EN); op(C_TK); op(C_EX); op(0);

    tag = "R8";                       // read while in normal mode after exit
    op(C_RD); op(0); op(0); op(0); op(0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule